// File: doc/BRIEF.md
# Reference Clock Presence and Frequency Identifier

This block watches an incoming reference clock using a trusted local timebase clock. It decides whether the reference toggles at all and, when it does, which of three telecom reference frequencies is present: 19.44 MHz, 77.76 MHz or 155.52 MHz. From that it selects the integer ratio used to divide the oscillator down for the frequency comparison of the recovered clock. When no activity is seen, the block drops its reference-active flag so that the lock alarm downstream is forced on, since lock status is then unknown.

The reference is first divided by a small prescaler in its own domain. A toggle bit crosses into the timebase domain through a three-flop synchronizer. Each change of that bit is one counted edge. Edges are counted over a fixed window of timebase cycles. The count is sorted into one of three bins, each centred on the nominal count with a guard band of one eighth of that count on either side. Every supported frequency is accurate to ±100 ppm and has a duty cycle between 40% and 60%, which keeps each one well inside its bin. A classification is committed only when two consecutive windows agree.

Top module: `refclk_identifier`

## Requirements
- R1: After reset, refActive and codeValid are 0, freqCode is 3 (the invalid code) and divRatio is 0.
- R2: Reference edges, divided by PRESCALE (default 16), are counted over WINDOW (default 2048) timebase cycles. A count within ±1/8 of the nominal count for 19.44, 77.76 or 155.52 MHz is classified as code 0, 1 or 2 respectively.
- R3: freqCode changes and codeValid rises only when two consecutive windows give the same in-bin class. A single window with a different class leaves freqCode unchanged.
- R4: While codeValid is 1, divRatio is 32 for code 0, 8 for code 1 and 4 for code 2. While codeValid is 0, divRatio is 0.
- R5: refActive rises at the end of the first window whose count falls in a bin.
- R6: One window with no edges changes no output. A second consecutive window with no edges clears refActive and codeValid and sets freqCode to 3.
- R7: A window whose count is nonzero but outside every bin at once sets freqCode to 3 and clears codeValid and refActive.
- R8: A reference with any duty cycle from 40% to 60% is classified the same as one with a 50% duty cycle.
- R9: codeValid high implies refActive high and a freqCode other than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock under observation |
| tbClk | input | 1 | Local timebase clock (50 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| refActive | output | 1 | Reference seen toggling at a frequency that falls in a bin |
| freqCode | output | 2 | 0: 19.44 MHz, 1: 77.76 MHz, 2: 155.52 MHz, 3: invalid |
| codeValid | output | 1 | freqCode is a confirmed classification |
| divRatio | output | DIV_W | Oscillator-to-reference divide ratio, 0 when not valid |

## Verification
The bench drives the reference at each nominal frequency, at 40% and 60% duty, and at off-nominal frequencies both inside the guard bands and between bins. It checks the code, valid flag and ratio against counts it computes from the window arithmetic. Frequency changes are timed at window boundaries, so single-window responses can be told apart from two-window confirmations. Both the hold after one changed window and the hold after one empty window are checked this way. Stopping the reference, and then switching from a valid state to an out-of-bin frequency, shows the difference between the delayed clear on a missing reference and the immediate clear on an out-of-bin count.

// File: rtl/refid_pkg.sv
`timescale 1ns/1ps
package refid_pkg;
  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_LOW  = 3'd1,
    CLS_MID  = 3'd2,
    CLS_HIGH = 3'd3,
    CLS_BAD  = 3'd4
  } winClass_e;

  typedef struct packed {
    logic latch;
  } dpCtl_t;

  localparam logic [1:0] CODE_INVALID = 2'd3;
endpackage

// File: rtl/refid_sync.sv
`timescale 1ns/1ps
module refid_sync #(
  parameter int unsigned PRESCALE = 16
) (
  input  logic refClk,
  input  logic tbClk,
  input  logic rst_n,
  output logic edgePulse
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] preCnt;
  logic          refTog;
  logic [2:0]    syncQ;

  // reference domain: divide down and toggle
  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      refTog <= 1'b0;
    end else if (preCnt == PW'(PRESCALE - 1)) begin
      preCnt <= '0;
      refTog <= ~refTog;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // timebase domain: two synchronizing stages plus one history stage
  always_ff @(posedge tbClk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[1:0], refTog};
  end

  assign edgePulse = syncQ[2] ^ syncQ[1];

  // at the supported rates a prescaled edge can never arrive on back-to-back cycles
  p_edge_spaced_r2: assert property (@(posedge tbClk) disable iff (!rst_n)
    edgePulse |=> !edgePulse);
endmodule

// File: rtl/refid_datapath.sv
`timescale 1ns/1ps
module refid_datapath
  import refid_pkg::*;
#(
  parameter int unsigned WINDOW   = 2048,
  parameter int unsigned PRESCALE = 16,
  parameter int unsigned TB_KHZ   = 50000,
  parameter int unsigned FREQ_KHZ [3] = '{19440, 77760, 155520}
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      edgePulse,
  input  dpCtl_t    ctl,
  output winClass_e winClass
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] edgeCnt;
  logic [CW-1:0] latchedCnt;
  logic [31:0]   cntW;
  logic [2:0]    binHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgeCnt    <= '0;
      latchedCnt <= '0;
    end else if (ctl.latch) begin
      latchedCnt <= edgeCnt + CW'(edgePulse);
      edgeCnt    <= '0;
    end else begin
      edgeCnt <= edgeCnt + CW'(edgePulse);
    end
  end

  assign cntW = 32'(latchedCnt);

  for (genvar b = 0; b < 3; b++) begin : g_bin
    localparam longint unsigned NOM_L =
      (longint'(WINDOW) * longint'(FREQ_KHZ[b])) / (longint'(TB_KHZ) * longint'(PRESCALE));
    localparam int unsigned NOM = int'(NOM_L);
    localparam int unsigned LO  = NOM - NOM / 8;
    localparam int unsigned HI  = NOM + NOM / 8;
    assign binHit[b] = (cntW >= LO) && (cntW <= HI);
  end

  always_comb begin
    if (cntW == 32'd0)  winClass = CLS_NONE;
    else if (binHit[0]) winClass = CLS_LOW;
    else if (binHit[1]) winClass = CLS_MID;
    else if (binHit[2]) winClass = CLS_HIGH;
    else                winClass = CLS_BAD;
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(edgeCnt) <= WINDOW);
endmodule

// File: rtl/refid_control.sv
`timescale 1ns/1ps
module refid_control
  import refid_pkg::*;
#(
  parameter int unsigned WINDOW = 2048,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned DIV_RATIO [3] = '{32, 8, 4}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  winClass_e        winClass,
  output dpCtl_t           ctl,
  output logic             refActive,
  output logic             codeValid,
  output logic [1:0]       freqCode,
  output logic [DIV_W-1:0] divRatio
);
  localparam int WCW = $clog2(WINDOW);

  logic [WCW-1:0] winCnt;
  logic           clsReady;
  logic           zeroSeen;
  winClass_e      prevClass;

  function automatic logic [1:0] classToCode(winClass_e c);
    case (c)
      CLS_LOW:  return 2'd0;
      CLS_MID:  return 2'd1;
      CLS_HIGH: return 2'd2;
      default:  return CODE_INVALID;
    endcase
  endfunction

  assign ctl.latch = (winCnt == WCW'(WINDOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winCnt   <= '0;
      clsReady <= 1'b0;
    end else begin
      winCnt   <= ctl.latch ? '0 : winCnt + 1'b1;
      clsReady <= ctl.latch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refActive <= 1'b0;
      codeValid <= 1'b0;
      freqCode  <= CODE_INVALID;
      zeroSeen  <= 1'b0;
      prevClass <= CLS_NONE;
    end else if (clsReady) begin
      prevClass <= winClass;
      case (winClass)
        CLS_NONE: begin
          zeroSeen <= 1'b1;
          if (zeroSeen) begin
            refActive <= 1'b0;
            codeValid <= 1'b0;
            freqCode  <= CODE_INVALID;
          end
        end
        CLS_BAD: begin
          zeroSeen  <= 1'b0;
          refActive <= 1'b0;
          codeValid <= 1'b0;
          freqCode  <= CODE_INVALID;
        end
        default: begin
          zeroSeen  <= 1'b0;
          refActive <= 1'b1;
          if (prevClass == winClass) begin
            codeValid <= 1'b1;
            freqCode  <= classToCode(winClass);
          end
        end
      endcase
    end
  end

  always_comb begin
    divRatio = '0;
    if (codeValid) begin
      case (freqCode)
        2'd0:    divRatio = DIV_W'(DIV_RATIO[0]);
        2'd1:    divRatio = DIV_W'(DIV_RATIO[1]);
        2'd2:    divRatio = DIV_W'(DIV_RATIO[2]);
        default: divRatio = '0;
      endcase
    end
  end

  p_valid_sane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    codeValid |-> (refActive && freqCode != CODE_INVALID));

  p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clsReady |=> $stable(freqCode) && $stable(codeValid));

  p_bad_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clsReady && winClass == CLS_BAD) |=> (!refActive && !codeValid));

  p_active_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clsReady && (winClass == CLS_LOW || winClass == CLS_MID || winClass == CLS_HIGH))
      |=> refActive);
endmodule

// File: rtl/refclk_identifier.sv
`timescale 1ns/1ps
module refclk_identifier
  import refid_pkg::*;
#(
  parameter int unsigned WINDOW   = 2048,
  parameter int unsigned PRESCALE = 16,
  parameter int unsigned TB_KHZ   = 50000,
  parameter int unsigned DIV_W    = 6,
  parameter int unsigned FREQ_KHZ  [3] = '{19440, 77760, 155520},
  parameter int unsigned DIV_RATIO [3] = '{32, 8, 4}
) (
  input  logic             refClk,
  input  logic             tbClk,
  input  logic             rst_n,
  output logic             refActive,
  output logic [1:0]       freqCode,
  output logic             codeValid,
  output logic [DIV_W-1:0] divRatio
);
  logic      edgePulse;
  dpCtl_t    ctl;
  winClass_e winClass;

  refid_sync #(.PRESCALE(PRESCALE)) u_sync (
    .refClk   (refClk),
    .tbClk    (tbClk),
    .rst_n    (rst_n),
    .edgePulse(edgePulse)
  );

  refid_datapath #(
    .WINDOW  (WINDOW),
    .PRESCALE(PRESCALE),
    .TB_KHZ  (TB_KHZ),
    .FREQ_KHZ(FREQ_KHZ)
  ) u_dp (
    .clk      (tbClk),
    .rst_n    (rst_n),
    .edgePulse(edgePulse),
    .ctl      (ctl),
    .winClass (winClass)
  );

  refid_control #(
    .WINDOW   (WINDOW),
    .DIV_W    (DIV_W),
    .DIV_RATIO(DIV_RATIO)
  ) u_ctl (
    .clk      (tbClk),
    .rst_n    (rst_n),
    .winClass (winClass),
    .ctl      (ctl),
    .refActive(refActive),
    .codeValid(codeValid),
    .freqCode (freqCode),
    .divRatio (divRatio)
  );
endmodule

// File: tb/refclk_identifier_test.sv
`timescale 1ns/1ps
module refclk_identifier_test;
  localparam int W      = 2048;
  localparam int P      = 16;
  localparam real TB_MHZ = 50.0;

  logic tbClk = 1'b0;
  logic refClk = 1'b0;
  logic rst_n = 1'b0;
  logic refOn = 1'b0;
  real  hiNs = 10.0;
  real  loNs = 10.0;

  logic       refActive;
  logic [1:0] freqCode;
  logic       codeValid;
  logic [5:0] divRatio;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  refclk_identifier uut (
    .refClk   (refClk),
    .tbClk    (tbClk),
    .rst_n    (rst_n),
    .refActive(refActive),
    .freqCode (freqCode),
    .codeValid(codeValid),
    .divRatio (divRatio)
  );

  always #10 tbClk = ~tbClk;

  always begin
    if (refOn) begin
      refClk = 1'b1;
      #(hiNs);
      refClk = 1'b0;
      #(loNs);
    end else begin
      refClk = 1'b0;
      wait (refOn);
    end
  end

  always @(posedge tbClk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkState(string req, int a, int v, int c, int d);
    check(req, "refActive", int'(refActive), a);
    check(req, "codeValid", int'(codeValid), v);
    check(req, "freqCode",  int'(freqCode),  c);
    check(req, "divRatio",  int'(divRatio),  d);
  endtask

  task automatic alignTo(int ph);
    @(negedge tbClk);
    while ((cyc % W) != ph) @(negedge tbClk);
  endtask

  // settle after the next window boundary, sample mid-window
  task automatic afterWindow();
    alignTo(0);
    alignTo(W / 2);
  endtask

  task automatic setRef(real mhz, real dutyPct);
    real per;
    per  = 1000.0 / mhz;
    hiNs = per * dutyPct / 100.0;
    loNs = per - hiNs;
    refOn = 1'b1;
  endtask

  function automatic int expCode(real mhz);
    real nomF[3];
    real cnt;
    real nom;
    nomF[0] = 19.44; nomF[1] = 77.76; nomF[2] = 155.52;
    cnt = real'(W) * mhz / (TB_MHZ * real'(P));
    for (int k = 0; k < 3; k++) begin
      nom = real'(W) * nomF[k] / (TB_MHZ * real'(P));
      if (cnt >= nom * 0.875 && cnt <= nom * 1.125) return k;
    end
    return 3;
  endfunction

  function automatic int expDiv(int code);
    case (code)
      0: return 32;
      1: return 8;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  initial begin
    #(190000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    real sweep[8];
    sweep[0] = 17.5;  sweep[1] = 21.0;  sweep[2] = 85.0;  sweep[3] = 140.0;
    sweep[4] = 10.0;  sweep[5] = 40.0;  sweep[6] = 120.0; sweep[7] = 250.0;

    repeat (5) @(negedge tbClk);
    checkState("R1", 0, 0, 3, 0);
    rst_n = 1'b1;
    @(negedge tbClk);
    checkState("R1", 0, 0, 3, 0);

    // R6: no reference at all stays invalid
    afterWindow(); afterWindow(); afterWindow();
    checkState("R6", 0, 0, 3, 0);

    // R5 / R3: 19.44 MHz, active after one window, valid after two
    alignTo(4); setRef(19.44, 50.0);
    afterWindow();
    checkState("R5", 1, 0, 3, 0);
    afterWindow();
    checkState("R2", 1, 1, 0, 32);

    // R3 / R8: switch to 77.76 MHz at 40% duty, holds one window
    alignTo(4); setRef(77.76, 40.0);
    afterWindow();
    checkState("R3", 1, 1, 0, 32);
    afterWindow();
    checkState("R8", 1, 1, 1, 8);

    // R4 / R8: 155.52 MHz at 60% duty
    alignTo(4); setRef(155.52, 60.0);
    afterWindow();
    checkState("R3", 1, 1, 1, 8);
    afterWindow();
    checkState("R4", 1, 1, 2, 4);

    // R6: stop near end of a window
    alignTo(W - 40); refOn = 1'b0;
    afterWindow();
    checkState("R6", 1, 1, 2, 4);
    afterWindow();
    checkState("R6", 1, 1, 2, 4);
    afterWindow();
    checkState("R6", 0, 0, 3, 0);

    // R7: out-of-bin frequency from idle
    alignTo(4); setRef(40.0, 50.0);
    afterWindow();
    checkState("R7", 0, 0, 3, 0);

    // R7: from a valid state, a single out-of-bin window clears at once
    alignTo(4); setRef(155.52, 50.0);
    afterWindow(); afterWindow();
    checkState("R4", 1, 1, 2, 4);
    alignTo(4); setRef(40.0, 50.0);
    afterWindow();
    checkState("R7", 0, 0, 3, 0);

    // R3: recovery after out-of-bin needs two agreeing windows
    alignTo(4); setRef(19.44, 40.0);
    afterWindow();
    checkState("R3", 1, 0, 3, 0);
    afterWindow();
    checkState("R8", 1, 1, 0, 32);

    // R2 / R7: sweep of off-nominal frequencies, expectations from window arithmetic
    foreach (sweep[i]) begin
      int ec;
      ec = expCode(sweep[i]);
      alignTo(4); setRef(sweep[i], 50.0);
      afterWindow(); afterWindow(); afterWindow();
      if (ec == 3) checkState("R7", 0, 0, 3, 0);
      else         checkState("R2", 1, 1, ec, expDiv(ec));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule